// File: doc/BRIEF.md
# Serial Register Write Port

This block is a write-only three-wire serial slave. A host lowers the active-low load line, shifts in an 8-bit register address and then one or more 24-bit data words on a data line, clocking each bit with a serial clock. It then raises the load line again. Each complete data word lands in a shadow register. While the load line stays low, the target address steps up by one after every word, so a run of registers can be loaded with a single address.

Shadow values reach the active registers, which drive a flat parallel bus, at one of two kinds of point. A small set of control registers is committed when the load line rises. All other registers wait for the video timing. After the frame, they commit on a chosen falling edge of horizontal sync within the next field, where a field begins at a falling edge of vertical sync. A hold bit can block that sync-timed commit. A self-clearing reset bit returns the whole bank to its default values.

All serial and sync inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain.

Top module: `sreg_load_port`

## Requirements
- R1: A frame is the load line low, then 8 address bits, then 24 data bits, each field least significant bit first. Bits are taken on serial clock rising edges. Address n (0 to 7) selects register n, whose active value sits on `reg_bus[24n+23:24n]`.
- R2: A data word cut short by the load line rising before its 24th bit changes no shadow or active register.
- R3: Register widths are: reg0 1, reg1 1, reg2 12, reg3 24, reg4 16, reg5 8, reg6 24, reg7 24 bits. Written bits above a register's width are dropped and read back as 0.
- R4: While the load line stays low, each further complete 24-bit word goes to the next higher address.
- R5: Registers 0, 1, 2 and 4 commit on the load line's rising edge. Registers 3, 5, 6 and 7 keep their active value at that edge and change only at a sync commit or a bank reset.
- R6: With reg2 = 0, pending sync-class data commits at the first horizontal sync falling edge after the next vertical sync falling edge. Horizontal edges before that vertical edge commit nothing.
- R7: reg2 (bits 11:0) selects the line. Horizontal sync falling edges are numbered from 0, starting at the first one after the vertical sync falling edge. The sync commit happens at the edge whose number equals reg2.
- R8: While reg1 bit 0 is 1, a qualifying horizontal edge commits nothing. After reg1 returns to 0, the pending values commit at the qualifying edge of the next field.
- R9: Writing 1 to reg0 returns every shadow and active register to its default and drops pending sync data. reg0 always reads 0.
- R10: After reset the active values are reg0 to reg2 = 0, reg3 = 0x030303, reg4 = 0x0404, reg5 = 0x05, reg6 = 0x060606, reg7 = 0x070707, and both strobes are low.
- R11: `load_commit` pulses high for exactly one cycle at each load line rise. `sync_commit` pulses high for one cycle at each sync commit and at no other time.
- R12: Words addressed to 8 or above, including ones reached by auto-increment, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_din | input | 1 | Serial data, least significant bit first |
| ser_load_n | input | 1 | Active-low frame enable, asynchronous |
| vsync | input | 1 | Vertical sync; a falling edge starts a field |
| hsync | input | 1 | Horizontal sync; falling edges count lines |
| reg_bus | output | 192 | Active values of all registers, 24 bits each |
| load_commit | output | 1 | One-cycle pulse on each load-line commit |
| sync_commit | output | 1 | One-cycle pulse on each sync-timed commit |

## Verification
The hardest case is data that is written but then left waiting on purpose. It is pending behind the hold bit, or waiting for a later line number, while the load line and sync edges keep arriving. To reach it, the stimulus first raises the hold bit through a load-line write and then queues sync-class data. It steps through horizontal edges across a field, clears the hold bit in the middle of that field, and confirms that nothing moves until the qualifying edge of the following field. The same pattern is used with a non-zero line number: the bank must stay unchanged through three edges and change on the fourth.

// File: rtl/sregp_pkg.sv
package sregp_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 24;
    localparam int LINE_W = 12;
    localparam int NREG   = 8;

    localparam int R_SWRST = 0;
    localparam int R_HOLD  = 1;
    localparam int R_ULINE = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        word_t             data;
    } wr_t;

    typedef enum logic {PH_ADDR, PH_DATA} phase_e;

    function automatic int unsigned reg_width(int i);
        if (i == R_SWRST || i == R_HOLD) return 1;
        if (i == R_ULINE)                return LINE_W;
        if (i % 4 == 0)                  return 16;
        if (i % 4 == 1)                  return 8;
        return DATA_W;
    endfunction

    function automatic word_t reg_mask(int i);
        int unsigned w;
        w = reg_width(i);
        if (w >= DATA_W) return '1;
        return word_t'((32'd1 << w) - 32'd1);
    endfunction

    function automatic word_t reg_default(int i);
        if (i <= R_ULINE) return '0;
        return reg_mask(i) & word_t'(32'h00010101 * i);
    endfunction

    function automatic bit reg_on_load(int i);
        return (i <= R_ULINE) || (i == 4);
    endfunction

endpackage

// File: rtl/sregp_sync.sv
module sregp_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/sregp_deser.sv
module sregp_deser
    import sregp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic frame_on,
    input  logic bit_tick,
    input  logic bit_val,
    output logic wr_valid,
    output wr_t  wr
);
    localparam int CW = $clog2(DATA_W);

    phase_e              phase_q;
    logic [CW-1:0]       cnt_q;
    logic [ADDR_W-2:0]   asr_q;
    logic [DATA_W-2:0]   dsr_q;
    logic [ADDR_W-1:0]   cur_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_ADDR;
            cnt_q      <= '0;
            asr_q      <= '0;
            dsr_q      <= '0;
            cur_addr_q <= '0;
            wr_valid   <= 1'b0;
            wr         <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (frame_start) begin
                phase_q <= PH_ADDR;
                cnt_q   <= '0;
            end else if (frame_on && bit_tick) begin
                case (phase_q)
                    PH_ADDR: begin
                        if (cnt_q == CW'(ADDR_W - 1)) begin
                            cur_addr_q <= {bit_val, asr_q};
                            phase_q    <= PH_DATA;
                            cnt_q      <= '0;
                        end else begin
                            asr_q <= {bit_val, asr_q[ADDR_W-2:1]};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt_q == CW'(DATA_W - 1)) begin
                            wr_valid   <= 1'b1;
                            wr.addr    <= cur_addr_q;
                            wr.data    <= {bit_val, dsr_q};
                            cur_addr_q <= cur_addr_q + 1'b1;
                            cnt_q      <= '0;
                        end else begin
                            dsr_q <= {bit_val, dsr_q[DATA_W-2:1]};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sregp_bank.sv
module sregp_bank
    import sregp_pkg::*;
#(
    parameter int NREG_P = NREG
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  wr_t                      wr,
    input  logic                     load_rise,
    input  logic                     vd_fall,
    input  logic                     hd_fall,
    output logic [NREG_P*DATA_W-1:0] reg_bus,
    output logic                     load_commit,
    output logic                     sync_commit
);
    localparam int IW = (NREG_P > 1) ? $clog2(NREG_P) : 1;

    logic [NREG_P-1:0] load_class;
    logic              swreq;
    logic              hold;
    logic [LINE_W-1:0] uline;
    logic              do_swrst, do_sync, in_range, wr_sync_hit;
    logic              dirty_q, pending_q, waiting_q;
    logic [LINE_W-1:0] line_q;

    assign hold     = reg_bus[R_HOLD*DATA_W];
    assign uline    = reg_bus[R_ULINE*DATA_W +: LINE_W];
    assign do_swrst = load_rise && swreq;
    assign do_sync  = waiting_q && hd_fall && !vd_fall && (line_q == uline) && !hold;
    assign in_range = wr.addr < ADDR_W'(NREG_P);
    assign wr_sync_hit = wr_valid && in_range && !load_class[wr.addr[IW-1:0]];

    for (genvar gi = 0; gi < NREG_P; gi++) begin : g_reg
        localparam word_t MASK  = reg_mask(gi);
        localparam word_t DEF   = reg_default(gi);
        localparam bit    ON_LD = reg_on_load(gi);

        word_t shadow_q, active_q;
        logic  commit_now;

        if (ON_LD) begin : g_ld
            assign commit_now = load_rise;
        end else begin : g_sy
            assign commit_now = do_sync;
        end

        if (gi == R_SWRST) begin : g_sw
            assign swreq = shadow_q[0];
        end

        assign load_class[gi] = ON_LD;

        always_ff @(posedge clk) begin
            if (rst || do_swrst) begin
                shadow_q <= DEF;
                active_q <= DEF;
            end else begin
                if (wr_valid && wr.addr == ADDR_W'(gi))
                    shadow_q <= wr.data & MASK;
                if (commit_now)
                    active_q <= shadow_q;
            end
        end

        assign reg_bus[gi*DATA_W +: DATA_W] = active_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty_q     <= 1'b0;
            pending_q   <= 1'b0;
            waiting_q   <= 1'b0;
            line_q      <= '0;
            load_commit <= 1'b0;
            sync_commit <= 1'b0;
        end else begin
            load_commit <= load_rise;
            sync_commit <= do_sync;
            if (do_swrst) begin
                dirty_q   <= 1'b0;
                pending_q <= 1'b0;
                waiting_q <= 1'b0;
                line_q    <= '0;
            end else begin
                if (load_rise)
                    dirty_q <= 1'b0;
                else if (wr_sync_hit)
                    dirty_q <= 1'b1;
                pending_q <= (pending_q && !do_sync) || (load_rise && dirty_q);
                if (vd_fall) begin
                    waiting_q <= pending_q;
                    line_q    <= '0;
                end else if (hd_fall && waiting_q) begin
                    if (line_q == uline)
                        waiting_q <= 1'b0;
                    else
                        line_q <= line_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sreg_load_port.sv
module sreg_load_port
    import sregp_pkg::*;
#(
    parameter int NREG_P = NREG
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk,
    input  logic                     ser_din,
    input  logic                     ser_load_n,
    input  logic                     vsync,
    input  logic                     hsync,
    output logic [NREG_P*DATA_W-1:0] reg_bus,
    output logic                     load_commit,
    output logic                     sync_commit
);
    localparam logic [4:0] SYNC_RST = 5'b00111;

    logic [4:0] s_now;
    logic       sck_s, sdi_s, ld_s, vd_s, hd_s;
    logic       sck_p, ld_p, vd_p, hd_p;
    logic       bit_tick, load_rise, load_fall, vd_fall, hd_fall;
    logic       wr_valid;
    wr_t        wr;

    sregp_sync #(.W(5), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_clk, ser_din, ser_load_n, vsync, hsync}),
        .dout (s_now)
    );

    assign {sck_s, sdi_s, ld_s, vd_s, hd_s} = s_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= 1'b0;
            ld_p  <= 1'b1;
            vd_p  <= 1'b1;
            hd_p  <= 1'b1;
        end else begin
            sck_p <= sck_s;
            ld_p  <= ld_s;
            vd_p  <= vd_s;
            hd_p  <= hd_s;
        end
    end

    assign bit_tick  = sck_s & ~sck_p;
    assign load_rise = ld_s & ~ld_p;
    assign load_fall = ~ld_s & ld_p;
    assign vd_fall   = ~vd_s & vd_p;
    assign hd_fall   = ~hd_s & hd_p;

    sregp_deser u_deser (
        .clk         (clk),
        .rst         (rst),
        .frame_start (load_fall),
        .frame_on    (~ld_s),
        .bit_tick    (bit_tick),
        .bit_val     (sdi_s),
        .wr_valid    (wr_valid),
        .wr          (wr)
    );

    sregp_bank #(.NREG_P(NREG_P)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr          (wr),
        .load_rise   (load_rise),
        .vd_fall     (vd_fall),
        .hd_fall     (hd_fall),
        .reg_bus     (reg_bus),
        .load_commit (load_commit),
        .sync_commit (sync_commit)
    );
endmodule

// File: rtl/sregp_chk.sv
module sregp_chk
    import sregp_pkg::*;
#(
    parameter int NREG_P = NREG
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NREG_P*DATA_W-1:0] reg_bus,
    input logic                     load_commit,
    input logic                     sync_commit
);
    AST_SWRST_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_bus[R_SWRST*DATA_W +: DATA_W] == '0);  // R9

    AST_LOAD_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
        load_commit |=> !load_commit);  // R11

    AST_SYNC_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
        sync_commit |=> !sync_commit);  // R11

    AST_HOLD_BLOCKS_SYNC: assert property (@(posedge clk) disable iff (rst)
        sync_commit |-> !$past(reg_bus[R_HOLD*DATA_W]));  // R8

    for (genvar gi = 0; gi < NREG_P; gi++) begin : g_chk
        localparam word_t MASK = reg_mask(gi);

        AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
            (reg_bus[gi*DATA_W +: DATA_W] & ~MASK) == '0);  // R3

        if (reg_on_load(gi)) begin : g_ld
            AST_LOAD_CLASS_STEADY: assert property (@(posedge clk) disable iff (rst)
                !$stable(reg_bus[gi*DATA_W +: DATA_W]) |-> load_commit);  // R5
        end else begin : g_sy
            AST_SYNC_CLASS_STEADY: assert property (@(posedge clk) disable iff (rst)
                !$stable(reg_bus[gi*DATA_W +: DATA_W]) |-> (sync_commit || load_commit));  // R5
        end
    end
endmodule

bind sreg_load_port sregp_chk #(.NREG_P(NREG_P)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_bus     (reg_bus),
    .load_commit (load_commit),
    .sync_commit (sync_commit)
);

// File: tb/test_sreg_load_port.sv
module test_sreg_load_port;
    localparam int N  = 8;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, sdi = 1'b0, lnd = 1'b1, vs = 1'b1, hs = 1'b1;
    logic [N*DW-1:0] bus;
    logic lc, sc;

    always #4 clk = ~clk;

    sreg_load_port i_sreg_load_port (
        .clk(clk), .rst(rst), .ser_clk(sck), .ser_din(sdi), .ser_load_n(lnd),
        .vsync(vs), .hsync(hs), .reg_bus(bus), .load_commit(lc), .sync_commit(sc)
    );

    int checks = 0, errors = 0;
    int lc_cnt = 0, sc_cnt = 0, wide = 0;
    logic lc_d = 1'b0, sc_d = 1'b0;
    bit done = 0;
    logic [DW-1:0] exp_act [N];

    // R11 strobe monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (lc) lc_cnt++;
            if (sc) sc_cnt++;
            if ((lc && lc_d) || (sc && sc_d)) wide++;
        end
        lc_d <= lc;
        sc_d <= sc;
    end

    function automatic logic [DW-1:0] dflt(int i);
        case (i)
            3: return 24'h030303;
            4: return 24'h000404;
            5: return 24'h000005;
            6: return 24'h060606;
            7: return 24'h070707;
            default: return 24'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) chk(tag, 32'(bus[i*DW +: DW]), 32'(exp_act[i]));
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbits(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) begin
            sdi = v[i]; wclk(3);
            sck = 1'b1; wclk(4);
            sck = 1'b0; wclk(1);
        end
    endtask

    task automatic fbegin(logic [7:0] a);
        lnd = 1'b0; wclk(4); sbits(32'(a), 8);
    endtask

    task automatic fend();
        wclk(4); lnd = 1'b1; wclk(10);
    endtask

    task automatic write1(logic [7:0] a, logic [23:0] d);
        fbegin(a); sbits(32'(d), 24); fend();
    endtask

    task automatic pulse_vd();
        vs = 1'b0; wclk(6); vs = 1'b1; wclk(10);
    endtask

    task automatic pulse_hd();
        hs = 1'b0; wclk(6); hs = 1'b1; wclk(10);
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) exp_act[i] = dflt(i);
        check_all("R10 reset value");
        chk("R10 load strobe low", 32'(lc), 0);
        chk("R10 sync strobe low", 32'(sc), 0);
    endtask

    task automatic t_load_write();
        int l0 = lc_cnt;
        write1(8'd4, 24'h12ABCD);
        exp_act[4] = 24'h00ABCD;
        check_all("R1 R3 R5 load-class write");
        chk("R11 one load strobe", 32'(lc_cnt), 32'(l0 + 1));
    endtask

    task automatic t_sync_default();
        int s0 = sc_cnt;
        write1(8'd3, 24'h123456);
        write1(8'd5, 24'hAB00C3);
        check_all("R5 sync class unchanged at load rise");
        pulse_hd();
        check_all("R6 hsync before vsync ignored");
        pulse_vd();
        check_all("R6 no commit at vsync");
        pulse_hd();
        exp_act[3] = 24'h123456;
        exp_act[5] = 24'h0000C3;
        check_all("R6 R3 commit at first hsync");
        chk("R11 one sync strobe", 32'(sc_cnt), 32'(s0 + 1));
        pulse_hd();
        chk("R11 no extra sync strobe", 32'(sc_cnt), 32'(s0 + 1));
    endtask

    task automatic t_autoinc();
        fbegin(8'd5);
        sbits(32'h111111, 24); sbits(32'h222222, 24); sbits(32'h333333, 24);
        fend();
        check_all("R4 nothing before field");
        pulse_vd(); pulse_hd();
        exp_act[5] = 24'h000011;
        exp_act[6] = 24'h222222;
        exp_act[7] = 24'h333333;
        check_all("R4 auto-increment");
        fbegin(8'd7);
        sbits(32'h444444, 24); sbits(32'h555555, 24);
        fend();
        write1(8'h20, 24'h999999);
        pulse_vd(); pulse_hd();
        exp_act[7] = 24'h444444;
        check_all("R12 out-of-range ignored");
    endtask

    task automatic t_partial();
        fbegin(8'd4); sbits(32'h00BEEF, 10); fend();
        check_all("R2 short word dropped");
        fbegin(8'd3); sbits(32'h0F0F0F, 24); sbits(32'h777777, 12); fend();
        check_all("R2 R5 after short tail");
        pulse_vd(); pulse_hd();
        exp_act[3] = 24'h0F0F0F;
        check_all("R2 full word kept, short tail dropped");
    endtask

    task automatic t_update_line();
        write1(8'd2, 24'h7F0003);
        exp_act[2] = 24'h000003;
        check_all("R3 R7 line register masked");
        write1(8'd6, 24'hC0FFEE);
        pulse_vd();
        for (int k = 0; k < 3; k++) begin
            pulse_hd();
            check_all("R7 before chosen line");
        end
        pulse_hd();
        exp_act[6] = 24'hC0FFEE;
        check_all("R7 commit on chosen line");
        write1(8'd2, 24'h0);
        exp_act[2] = 24'h0;
    endtask

    task automatic t_hold();
        write1(8'd1, 24'h000001);
        exp_act[1] = 24'h000001;
        write1(8'd7, 24'hDEAD01);
        pulse_vd(); pulse_hd();
        check_all("R8 hold blocks qualifying edge");
        pulse_hd();
        check_all("R8 hold later edge");
        write1(8'd1, 24'h0);
        exp_act[1] = 24'h0;
        pulse_hd();
        check_all("R8 waits for next field");
        pulse_vd(); pulse_hd();
        exp_act[7] = 24'hDEAD01;
        check_all("R8 commit after release");
    endtask

    task automatic t_swreset();
        int s0;
        write1(8'd6, 24'hABCDEF);
        write1(8'd4, 24'h001234);
        exp_act[4] = 24'h001234;
        check_all("R9 before bank reset");
        write1(8'd0, 24'h000001);
        for (int i = 0; i < N; i++) exp_act[i] = dflt(i);
        check_all("R9 bank reset to defaults");
        s0 = sc_cnt;
        pulse_vd(); pulse_hd();
        check_all("R9 pending dropped");
        chk("R9 R11 no sync commit", 32'(sc_cnt), 32'(s0));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL all watchdog act=hung exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(5);
        t_reset();
        t_load_write();
        t_sync_default();
        t_autoinc();
        t_partial();
        t_update_line();
        t_hold();
        t_swreset();
        chk("R11 strobe width", 32'(wide), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule